// File: doc/BRIEF.md
# Dual-Image Reconfiguration Controller

This block lets on-chip logic choose which of two stored configuration images the device should boot next, and then ask for that image to be loaded. A small memory-mapped slave with a 3-bit word address, 32-bit write and read data, and read and write strobes gives access to three functions. The client can select the image, start a reconfiguration, and clear a watchdog. A status word reports when the block is busy and whether a start request was dropped.

When a start request is accepted, the block waits a fixed number of clock cycles and then gives a one-cycle reconfiguration request pulse. The selected image is always shown on an output port. A watchdog runs while its static enable input is high. If the client does not clear it in time, the block forces the factory image and starts a reconfiguration by itself. A reconfiguration resets all user logic, so the newly loaded image must clear the watchdog again after its own reset. The real flash access and the configuration engine sit outside this block.

Top module: `reimg_ctl`

## Requirements
- R1: After a synchronous active-high reset, reconf_req, wd_timeout, boot_img and rdata are 0, and the status word reads 0.
- R2: A write to word 1 with data 1 selects image 0 (application), and a write with data 3 selects image 1 (factory). Any other data leaves the selection unchanged. boot_img shows the selection, and a read of word 1 returns it in bit 0.
- R3: Status bit 0 (busy) of word 3 is high for exactly BUSY_CYCLES cycles after the cycle of any write to word 1. It is also high while an accepted reconfiguration is still waiting.
- R4: A write to word 0 with bit 0 set, made while busy is low, makes reconf_req pulse high for one cycle. The pulse comes TRIG_DELAY+1 cycles after the write cycle.
- R5: A start request written while busy is high is ignored and gives no pulse. It sets status bit 1 of word 3. A read of word 3 returns that bit and then clears it.
- R6: A write to word 0 with bit 1 set restarts the watchdog count. Data 3 both starts a reconfiguration and clears the watchdog. Data 0 has no effect.
- R7: With wd_en high, the watchdog times out when it is not cleared for WD_LIMIT counting cycles. It does not count while a reconfiguration waits. On timeout, wd_timeout pulses for one cycle, boot_img becomes 1 in that same cycle, and reconf_req follows TRIG_DELAY+1 cycles later.
- R8: With wd_en low, the watchdog never times out.
- R9: A watchdog clear in the same cycle as the expiry wins, and no timeout occurs. A start request in the same cycle as the expiry merges with it: there is one pulse, the factory image is used, and no drop is recorded.
- R10: Read data is registered and is valid in the cycle after the read strobe. It is 0 when no read was made. Words 0, 2, 4, 5, 6 and 7 read as 0, and writes to words 2 and 4 through 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Static watchdog enable |
| addr | input | 3 | Word address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| boot_img | output | 1 | Selected image (0 application, 1 factory) |
| wd_timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
A client write to the control word can land in the same clock cycle as the watchdog expiry, and the design must resolve that collision deterministically. The bench sweeps the clear write over every cycle from the first count to the exact expiry cycle. It requires the next timeout exactly WD_LIMIT cycles after each clear, including when the clear coincides with the expiry. It also places a start request right on the expiry cycle. There it expects a single request pulse at the delay set by the timeout, with the factory image selected and the drop flag still clear.

// File: rtl/reimg_ctl.sv
module reimg_ctl #(
  parameter int WD_LIMIT    = 1000000,
  parameter int BUSY_CYCLES = 8,
  parameter int TRIG_DELAY  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wd_en,
  input  logic [2:0]  addr,
  input  logic        wr,
  input  logic        rd,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        reconf_req,
  output logic        boot_img,
  output logic        wd_timeout
);
  localparam int WDW = $clog2(WD_LIMIT + 1);
  localparam int BW  = $clog2(BUSY_CYCLES + 1);
  localparam int DW  = $clog2(TRIG_DELAY + 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WD_LIMIT - 1);

  logic [WDW-1:0] wd_cnt;
  logic [BW-1:0]  busy_cnt;
  logic [DW-1:0]  dly_cnt;
  logic           pending, dropped;

  wire wr_ctl = wr && addr == 3'd0;
  wire trig   = wr_ctl && wdata[0];
  wire clr    = wr_ctl && wdata[1];
  wire wr_sel = wr && addr == 3'd1;
  wire busy   = (busy_cnt != '0) || pending;
  wire expire = wd_en && !pending && !clr && wd_cnt == WD_LAST;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (addr)
      3'd1: rd_mux = {31'd0, boot_img};
      3'd3: rd_mux = {30'd0, dropped, busy};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cnt     <= '0;
      busy_cnt   <= '0;
      dly_cnt    <= '0;
      pending    <= 1'b0;
      dropped    <= 1'b0;
      boot_img   <= 1'b0;
      reconf_req <= 1'b0;
      wd_timeout <= 1'b0;
      rdata      <= '0;
    end else begin
      reconf_req <= 1'b0;
      wd_timeout <= 1'b0;
      rdata      <= rd ? rd_mux : '0;

      if (wr_sel) begin
        busy_cnt <= BW'(BUSY_CYCLES);
        if (wdata == 32'd1)      boot_img <= 1'b0;
        else if (wdata == 32'd3) boot_img <= 1'b1;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - 1'b1;
      end

      if (expire) begin
        boot_img   <= 1'b1;
        wd_timeout <= 1'b1;
        pending    <= 1'b1;
        dly_cnt    <= DW'(TRIG_DELAY);
      end else if (trig && !busy) begin
        pending <= 1'b1;
        dly_cnt <= DW'(TRIG_DELAY);
      end else if (pending) begin
        if (dly_cnt == '0) begin
          pending    <= 1'b0;
          reconf_req <= 1'b1;
        end else begin
          dly_cnt <= dly_cnt - 1'b1;
        end
      end

      if (clr || expire)            wd_cnt <= '0;
      else if (wd_en && !pending)   wd_cnt <= wd_cnt + 1'b1;

      if (trig && busy && !expire)        dropped <= 1'b1;
      else if (rd && addr == 3'd3)        dropped <= 1'b0;
    end
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reconf_req |=> !reconf_req); // R4
  AST_REQ_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(reconf_req) |-> $past(busy)); // R3
  AST_TIMEOUT_FACTORY: assert property (@(posedge clk) disable iff (rst)
    wd_timeout |-> boot_img); // R7
  AST_TIMEOUT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    wd_timeout |-> $past(wd_en)); // R8
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (trig && busy && !expire) |=> dropped); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !wd_timeout); // R9
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == 32'd0); // R10
endmodule

// File: tb/reimg_ctl_bench.sv
module reimg_ctl_bench;
  localparam int WDL = 40;
  localparam int BSY = 3;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_en = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic reconf_req, boot_img, wd_timeout;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  reimg_ctl #(.WD_LIMIT(WDL), .BUSY_CYCLES(BSY), .TRIG_DELAY(DLY)) u_reimg_ctl (
    .clk(clk), .rst(rst), .wd_en(wd_en), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .reconf_req(reconf_req),
    .boot_img(boot_img), .wd_timeout(wd_timeout));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] a, input logic w, input logic r, input logic [31:0] d);
    addr = a; wr = w; rd = r; wdata = d;
    @(negedge clk);
    addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic en);
    rst = 1'b1; wd_en = en;
    idle(2);
    rst = 1'b0;
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    chk("R1 req", reconf_req, 0);
    chk("R1 img", boot_img, 0);
    chk("R1 tmo", wd_timeout, 0);
    chk("R1 rdata", rdata, 0);
    step(3, 0, 1, 0);
    chk("R1 status", rdata, 0);

    // R2 image select
    step(1, 1, 0, 3); chk("R2 sel3", boot_img, 1);
    idle(BSY + 2);
    step(1, 0, 1, 0); chk("R2 read", rdata, 1);
    step(1, 1, 0, 2); chk("R2 data2", boot_img, 1);
    step(1, 1, 0, 1); chk("R2 sel1", boot_img, 0);
    step(1, 1, 0, 7); chk("R2 data7", boot_img, 0);
    idle(BSY + 2);

    // R10 unused words
    for (int a = 2; a < 8; a++) if (a != 3) step(3'(a), 1, 0, 32'hffff_ffff);
    chk("R10 wr ignored img", boot_img, 0);
    chk("R10 wr ignored req", reconf_req, 0);
    for (int a = 0; a < 8; a++) if (a != 1 && a != 3) begin
      step(3'(a), 0, 1, 0);
      chk("R10 unused read", rdata, 0);
    end
    idle(1);
    chk("R10 idle rdata", rdata, 0);

    // R3 busy window after selection write
    for (int k = 1; k <= BSY + 1; k++) begin
      step(1, 1, 0, 1);
      idle(k - 1);
      step(3, 0, 1, 0);
      chk("R3 busy window", rdata[0], (k <= BSY));
      idle(BSY + 2);
    end

    // R4/R5 trigger against busy window
    for (int k = 1; k <= BSY + 1; k++) begin
      bit acc;
      acc = (k > BSY);
      step(1, 1, 0, 1);
      idle(k - 1);
      step(0, 1, 0, 1);
      for (int j = 1; j <= DLY + 2; j++) begin
        idle(1);
        chk(acc ? "R4 pulse" : "R5 no pulse", reconf_req, (acc && j == DLY + 1));
      end
      idle(3);
      step(3, 0, 1, 0);
      chk("R5 drop flag", rdata, acc ? 0 : 2);
      step(3, 0, 1, 0);
      chk("R5 drop cleared", rdata, 0);
    end

    // R3 busy while waiting
    step(0, 1, 0, 1);
    step(3, 0, 1, 0);
    chk("R3 busy pending", rdata, 1);
    idle(DLY + 3);

    // R8 disabled watchdog
    do_reset(1'b0);
    for (int j = 1; j <= 3 * WDL; j++) begin
      idle(1);
      chk("R8 no timeout", {wd_timeout, reconf_req}, 0);
    end

    // R7 plus R6 no-effect writes
    do_reset(1'b1);
    for (int j = 1; j <= WDL + DLY + 2; j++) begin
      if (j == 5)       step(0, 1, 0, 0);
      else if (j == 9)  step(5, 1, 0, 3);
      else if (j == 12) step(2, 1, 0, 2);
      else              idle(1);
      chk("R7 timeout", wd_timeout, (j == WDL));
      chk("R7 factory", boot_img, (j >= WDL));
      chk("R7 req", reconf_req, (j == WDL + DLY + 1));
    end

    // R6/R9 clear sweep incl. same-cycle clear
    for (int c = 1; c <= WDL; c++) begin
      do_reset(1'b1);
      for (int j = 1; j <= c + WDL + 1; j++) begin
        if (j == c) step(0, 1, 0, 2); else idle(1);
        chk((c == WDL) ? "R9 clear wins" : "R6 clear restart", wd_timeout, (j == c + WDL));
      end
    end

    // R6 data 3 triggers and clears
    do_reset(1'b1);
    for (int j = 1; j <= 22 + DLY + WDL; j++) begin
      if (j == 20) step(0, 1, 0, 3); else idle(1);
      chk("R6 both req", reconf_req, (j == 21 + DLY));
      chk("R6 both tmo", wd_timeout, (j == 21 + DLY + WDL));
    end

    // R9 trigger merges with expiry
    do_reset(1'b1);
    for (int j = 1; j <= WDL + DLY + 2; j++) begin
      if (j == WDL) step(0, 1, 0, 1); else idle(1);
      chk("R9 merge tmo", wd_timeout, (j == WDL));
      chk("R9 merge req", reconf_req, (j == WDL + DLY + 1));
    end
    chk("R9 merge img", boot_img, 1);
    step(3, 0, 1, 0);
    chk("R9 merge no drop", rdata, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule